// File: doc/BRIEF.md
# Masked Packed Saturating Unsigned Adder

This datapath unit adds two packed vectors lane by lane and clamps every lane that overflows to its all-ones value instead of letting it wrap. The lanes are either 8 or 16 bits wide. The active part of the 512-bit datapath is 64, 128, 256 or 512 bits. Above that active part, the bits are either cleared or copied from the prior destination value.

A per-lane write mask limits which lanes receive the sum. A lane whose mask bit is clear either keeps its prior destination value (merge) or is written with zero (zeroing). The mask can also be disabled as a whole. At 64 bits the mask never applies. For the two-operand forms, the caller passes the destination as the first source as well.

Each operation is presented with a one-cycle `valid_i`. The result is registered and shown one clock later with a one-cycle `valid_o`, and it holds its value until the next operation. No flags or exceptions are produced.

Top module: `sat_add_vec`

## Requirements
- R1: In byte lanes (`word_mode_i`=0) each result byte is a+b when a+b <= 0xFF, else 0xFF.
- R2: In word lanes (`word_mode_i`=1) each 16-bit lane is a+b when a+b <= 0xFFFF, else 0xFFFF.
- R3: A lane inside the active length receives the saturated sum when its mask bit is set or when `mask_en_i`=0.
- R4: A lane inside the active length with a clear mask bit keeps its `dst_i` value when `mask_en_i`=1 and `zero_mode_i`=0.
- R5: A lane inside the active length with a clear mask bit is written with zero when `mask_en_i`=1 and `zero_mode_i`=1.
- R6: `vlen_i` codes 0,1,2,3 give an active length of 64,128,256,512 bits, which is 8,16,32,64 byte lanes or 4,8,16,32 word lanes. Mask bit j belongs to lane j, counting from the least significant lane. Mask bits at or above the active lane count have no effect.
- R7: With `keep_upper_i`=0, all result bits from the active length up to bit 511 are zero.
- R8: With `keep_upper_i`=1, all result bits from the active length up to bit 511 equal `dst_i`.
- R9: With `vlen_i`=0, every lane receives the saturated sum whatever `mask_en_i`, `zero_mode_i` and `mask_i` are.
- R10: `valid_o` is high for exactly the one cycle after each cycle with `valid_i` high. `res_o` changes only in that cycle and holds its value otherwise.
- R11: While `rst_ni` is low, `res_o` and `valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| word_mode_i | input | 1 | 0: 8-bit lanes, 1: 16-bit lanes |
| vlen_i | input | 2 | Active length code: 0=64, 1=128, 2=256, 3=512 bits |
| mask_en_i | input | 1 | Enables the write mask |
| zero_mode_i | input | 1 | Masked-off lanes: 0 merge, 1 zero |
| keep_upper_i | input | 1 | Bits above active length: 0 clear, 1 keep `dst_i` |
| src_a_i | input | 512 | First source vector |
| src_b_i | input | 512 | Second source vector |
| dst_i | input | 512 | Prior destination value |
| mask_i | input | 64 | Per-lane write mask |
| valid_o | output | 1 | Result strobe |
| res_o | output | 512 | Registered result |

## Verification
Saturation and masking meet in the same lane in the same cycle. The clamped sum is computed first, and the mask then decides whether that lane shows the clamp, the old destination or zero. The handling of the upper bits also meets a changing lane width, because byte and word lanes end on the same active boundary. The bench provokes these cases by sweeping every combination of lane width, length, mask enable, merge/zero and upper-bit mode with near-saturating operands and pseudo-random masks that also have bits set above the active lane count. Each result is judged against an arithmetic lane model that builds its answer lane by lane, independently of the byte-based structure of the design.

// File: rtl/sat_add_pkg.sv
package sat_add_pkg;
  localparam int unsigned DATA_W  = 512;
  localparam int unsigned NBYTES  = DATA_W / 8;
  localparam int unsigned NWORDS  = DATA_W / 16;
  localparam int unsigned VLEN_W  = 2;

  typedef enum logic [VLEN_W-1:0] {
    VL_64  = 2'd0,
    VL_128 = 2'd1,
    VL_256 = 2'd2,
    VL_512 = 2'd3
  } vlen_e;

  // active byte count for a length code
  function automatic int unsigned act_bytes(logic [VLEN_W-1:0] code);
    return 8 << code;
  endfunction
endpackage

// File: rtl/sat_add_core.sv
module sat_add_core
  import sat_add_pkg::*;
#(
  parameter int unsigned NW = NWORDS
) (
  input  logic            word_mode_i,
  input  logic [16*NW-1:0] a_i,
  input  logic [16*NW-1:0] b_i,
  output logic [16*NW-1:0] sum_o
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [8:0]  lo_s, hi_s;
    logic [16:0] w_s;
    logic [15:0] byte_r, word_r;
    always_comb begin
      lo_s   = {1'b0, a_i[16*g +: 8]}   + {1'b0, b_i[16*g +: 8]};
      hi_s   = {1'b0, a_i[16*g+8 +: 8]} + {1'b0, b_i[16*g+8 +: 8]};
      w_s    = {1'b0, a_i[16*g +: 16]}  + {1'b0, b_i[16*g +: 16]};
      byte_r = {hi_s[8] ? 8'hFF : hi_s[7:0], lo_s[8] ? 8'hFF : lo_s[7:0]};
      word_r = w_s[16] ? 16'hFFFF : w_s[15:0];
      sum_o[16*g +: 16] = word_mode_i ? word_r : byte_r;
    end
    // R1
    always_comb begin
      sat_floor_chk: assert (word_mode_i ||
        (sum_o[16*g +: 8] >= a_i[16*g +: 8] && sum_o[16*g+8 +: 8] >= a_i[16*g+8 +: 8]));
    end
  end
endmodule

// File: rtl/sat_add_merge.sv
module sat_add_merge
  import sat_add_pkg::*;
#(
  parameter int unsigned NB = NBYTES
) (
  input  logic              word_mode_i,
  input  logic [VLEN_W-1:0] vlen_i,
  input  logic              mask_en_i,
  input  logic              zero_mode_i,
  input  logic              keep_upper_i,
  input  logic [8*NB-1:0]   sum_i,
  input  logic [8*NB-1:0]   dst_i,
  input  logic [NB-1:0]     mask_i,
  output logic [8*NB-1:0]   res_o
);
  localparam int unsigned CNT_W = $clog2(NB) + 2;

  logic [CNT_W-1:0] n_act;
  logic             no_mask;

  assign n_act   = CNT_W'(act_bytes(vlen_i));
  assign no_mask = (vlen_e'(vlen_i) == VL_64) || !mask_en_i;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic active, mbit, take;
    assign active = CNT_W'(k) < n_act;
    assign mbit   = word_mode_i ? mask_i[k/2] : mask_i[k];
    assign take   = no_mask || mbit;
    always_comb begin
      if (!active)   res_o[8*k +: 8] = keep_upper_i ? dst_i[8*k +: 8] : 8'h00;
      else if (take) res_o[8*k +: 8] = sum_i[8*k +: 8];
      else           res_o[8*k +: 8] = zero_mode_i ? 8'h00 : dst_i[8*k +: 8];
    end
  end
endmodule

// File: rtl/sat_add_vec.sv
module sat_add_vec
  import sat_add_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              word_mode_i,
  input  logic [1:0]        vlen_i,
  input  logic              mask_en_i,
  input  logic              zero_mode_i,
  input  logic              keep_upper_i,
  input  logic [DW-1:0]     src_a_i,
  input  logic [DW-1:0]     src_b_i,
  input  logic [DW-1:0]     dst_i,
  input  logic [DW/8-1:0]   mask_i,
  output logic              valid_o,
  output logic [DW-1:0]     res_o
);
  localparam int unsigned NB = DW / 8;
  localparam int unsigned NW = DW / 16;

  logic [DW-1:0] sum_w, sel_w;

  sat_add_core #(.NW(NW)) i_core (
    .word_mode_i (word_mode_i),
    .a_i         (src_a_i),
    .b_i         (src_b_i),
    .sum_o       (sum_w)
  );

  sat_add_merge #(.NB(NB)) i_merge (
    .word_mode_i  (word_mode_i),
    .vlen_i       (vlen_i),
    .mask_en_i    (mask_en_i),
    .zero_mode_i  (zero_mode_i),
    .keep_upper_i (keep_upper_i),
    .sum_i        (sum_w),
    .dst_i        (dst_i),
    .mask_i       (mask_i),
    .res_o        (sel_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= sel_w;
    end
  end

  // R10
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(res_o)));
  // R7
  upper_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !keep_upper_i && vlen_i == 2'd0) |=> (res_o[DW-1:64] == '0));
  // R5
  zero_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_en_i && zero_mode_i && vlen_i != 2'd0 && mask_i == '0)
      |=> (res_o[127:0] == '0));
endmodule

// File: tb/test_sat_add_vec.sv
module test_sat_add_vec;
  localparam int DW = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_i = 1'b0, word_mode = 1'b0, mask_en = 1'b0, zero_mode = 1'b0, keep_up = 1'b0;
  logic [1:0]    vlen = 2'd0;
  logic [DW-1:0] a = '0, b = '0, d = '0;
  logic [63:0]   m = '0;
  logic          valid_o;
  logic [DW-1:0] res_o;

  int checks = 0, bad = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  sat_add_vec i_sat_add_vec (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .word_mode_i(word_mode),
    .vlen_i(vlen), .mask_en_i(mask_en), .zero_mode_i(zero_mode),
    .keep_upper_i(keep_up), .src_a_i(a), .src_b_i(b), .dst_i(d),
    .mask_i(m), .valid_o(valid_o), .res_o(res_o)
  );

  function automatic logic [63:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
    return seed;
  endfunction

  function automatic logic [DW-1:0] model(logic w, logic [1:0] vl, logic me, logic zm,
      logic ku, logic [DW-1:0] sa, logic [DW-1:0] sb, logic [DW-1:0] sd, logic [63:0] mk);
    logic [DW-1:0] r;
    int bits, lanes;
    bits  = 64 << vl;
    lanes = w ? bits / 16 : bits / 8;
    r = ku ? sd : '0;
    for (int j = 0; j < bits; j++) r[j] = 1'b0;
    for (int j = 0; j < lanes; j++) begin
      int s, lim;
      logic on;
      on = (vl == 0) || !me || mk[j];
      if (w) begin
        s = int'(sa[16*j +: 16]) + int'(sb[16*j +: 16]); lim = 65535;
        if (s > lim) s = lim;
        r[16*j +: 16] = on ? 16'(s) : (zm ? 16'h0 : sd[16*j +: 16]);
      end else begin
        s = int'(sa[8*j +: 8]) + int'(sb[8*j +: 8]); lim = 255;
        if (s > lim) s = lim;
        r[8*j +: 8] = on ? 8'(s) : (zm ? 8'h0 : sd[8*j +: 8]);
      end
    end
    return r;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, bit hold);
    logic [DW-1:0] exp, prev;
    exp = model(word_mode, vlen, mask_en, zero_mode, keep_up, a, b, d, m);
    @(negedge clk); valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    chk("R10 valid", {511'b0, valid_o}, {511'b0, 1'b1});
    chk(req, res_o, exp);
    if (hold) begin
      prev = res_o;
      a = ~a; m = ~m;
      @(negedge clk);
      chk("R10 idle", {511'b0, valid_o}, '0);
      chk("R10 hold", res_o, prev);
    end
  endtask

  function automatic logic [DW-1:0] rvec(int edge_mode);
    logic [DW-1:0] v;
    for (int q = 0; q < DW / 64; q++) v[64*q +: 64] = rnd();
    if (edge_mode == 1) for (int q = 0; q < DW / 8; q++) v[8*q+7] = 1'b1;
    return v;
  endfunction

  initial begin
    #1;
    chk("R11 valid", {511'b0, valid_o}, '0);
    chk("R11 res", res_o, '0);
    repeat (3) @(negedge clk);
    chk("R11 res held", res_o, '0);
    rst_n = 1'b1;

    // exhaustive byte pairs, 64 per op (R1)
    vlen = 2'd3;
    for (int i = 0; i < 1024; i++) begin
      for (int k = 0; k < 64; k++) begin
        a[8*k +: 8] = 8'((i * 64 + k) >> 8);
        b[8*k +: 8] = 8'(i * 64 + k);
      end
      run_op("R1 byte sat", 1'b0);
    end

    // word lanes near and at the clamp (R2)
    word_mode = 1'b1;
    for (int i = 0; i < 200; i++) begin
      a = rvec(i % 2); b = rvec(i % 2);
      if (i == 0) begin a = {32{16'hFFFF}}; b = {32{16'h0001}}; end
      if (i == 1) begin a = {32{16'h8000}}; b = {32{16'h7FFF}}; end
      run_op("R2 word sat", 1'b0);
    end

    // full control sweep: R3 R4 R5 R6 R7 R8 R9
    for (int c = 0; c < 64; c++) begin
      for (int rep = 0; rep < 4; rep++) begin
        word_mode = c[0]; vlen = c[2:1]; mask_en = c[3]; zero_mode = c[4]; keep_up = c[5];
        a = rvec(rep % 2); b = rvec(rep % 2); d = rvec(0); m = rnd();
        if (rep == 3) m = '0;
        run_op(vlen == 0 ? "R9 narrow" : (keep_up ? "R8 keep" : "R3 R4 R5 R6 R7 mask"), rep == 0);
      end
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #900000;
    checks++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule